// File: doc/BRIEF.md
# Filtered Interrupt Merger

This block gathers a set of active-low interrupt requests, one per downstream channel, and turns them into a single active-low request toward the host. Each request line first passes through a synchronizer and then through its own asymmetric pulse-width filter. The filter ignores an assertion (low level) that is shorter than one clock-count threshold. It ignores a release (high level) that is shorter than a second, shorter threshold. The filtered lines are combined so that the merged request is active while any filtered line is active.

The merged request comes out twice: as a plain logic level and as a pull-low enable for an open-drain pad. Both are registered. A one-cycle snapshot strobe, raised by the register read path when a read of the control byte begins, copies the filtered state of every channel into an active-high status vector. The read path places status bit n in control-byte bit 4+n. No channel-select input exists, because detection never depends on which channel is routed.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `irq_out_n` is 1, `irq_pull_en` is 0 and `irq_status` is all zeros; every filtered line starts inactive (high).
- R2: `irq_out_n` is 0 while at least one filtered line is low, and it returns to 1 only when all filtered lines are high.
- R3: A low level on an input that lasts fewer than `LOW_REJECT_CYC` clock cycles is ignored and `irq_out_n` stays 1; a low level that lasts exactly `LOW_REJECT_CYC` cycles is accepted.
- R4: A high gap on an active input that lasts fewer than `HIGH_REJECT_CYC` cycles is ignored and `irq_out_n` stays 0; a gap of `HIGH_REJECT_CYC` cycles or more releases the channel.
- R5: An accepted assertion shows on `irq_out_n` `SYNC_STAGES + LOW_REJECT_CYC + 1` rising edges after the input falls, and a release shows `SYNC_STAGES + HIGH_REJECT_CYC + 1` edges after the last input rises; with the defaults at 50 MHz these are within 4 µs and 2 µs.
- R6: One edge after a cycle with `snap_req` high, `irq_status[n]` is 1 exactly when channel n's filtered line is low (active); the read path maps bit n to control-byte bit 4+n.
- R7: `irq_status` keeps its value in every cycle without `snap_req`; it is not sticky, so a later snapshot after a release reads 0 for that channel.
- R8: `irq_pull_en` is always the complement of `irq_out_n`.
- R9: Every channel is filtered and reported independently of the others and of any channel routing; each channel alone can drive the merged request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in_n | input | NUM_CH | Asynchronous active-low interrupt requests, one per channel |
| snap_req | input | 1 | One-cycle strobe that captures the status vector |
| irq_out_n | output | 1 | Merged active-low interrupt level |
| irq_pull_en | output | 1 | Pull-low enable for an open-drain interrupt pad |
| irq_status | output | NUM_CH | Captured active-high status, one bit per channel |

## Verification
On every cycle, assertions check that the pull enable mirrors the level output, that the status vector moves only after a snapshot strobe and then equals the inverted filtered lines, that any active filtered line pulls the merged output low, that a filtered line changes only after its synchronized input has stayed at the new level for the required run length, and that the filter counters stay within bounds. Only the bench scenarios can show the exact threshold behaviour: a pulse one cycle short is rejected while one of full length is accepted, an exact edge-to-output latency holds, several channels overlap and release one by one, and a status read after a release no longer reports that channel.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

  localparam int unsigned DEF_NUM_CH    = 4;
  localparam int unsigned DEF_SYNC      = 2;
  localparam int unsigned DEF_LOW_CYC   = 50;
  localparam int unsigned DEF_HIGH_CYC  = 25;

  // Width of a counter that must reach the larger of two thresholds.
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // Larger of two thresholds, used for counter bounds.
  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '1;
        else     stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '1;
        else     stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/irq_glitch_filter.sv
`timescale 1ns/1ps
module irq_glitch_filter
  import irq_agg_pkg::*;
#(
  parameter int unsigned LOW_CYC  = DEF_LOW_CYC,
  parameter int unsigned HIGH_CYC = DEF_HIGH_CYC
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  output logic filt_n
);

  localparam int unsigned CW     = cnt_bits(LOW_CYC, HIGH_CYC);
  localparam int unsigned CMAX   = max_of(LOW_CYC, HIGH_CYC);
  localparam logic [CW-1:0] LIM_LO = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(CMAX);

  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // Waiting for a low while high uses the assert threshold, else the release one.
  assign limit = filt_q ? LIM_LO : LIM_HI;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_n == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == limit) begin
      filt_q <= sync_n;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_n = filt_q;

  // Independent run-length tracker for the checks below.
  logic          prev_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      prev_q <= sync_n;
      if (sync_n != prev_q)   run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  // R3: a filtered assertion only follows a long enough low run
  a_r3_low_run: assert property (@(posedge clk) disable iff (rst)
    $fell(filt_q) |-> ((int'($past(run_q)) + 2 >= int'(LOW_CYC)) && !$past(sync_n)));

  // R4: a filtered release only follows a long enough high run
  a_r4_high_run: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_q) |-> ((int'($past(run_q)) + 2 >= int'(HIGH_CYC)) && $past(sync_n)));

  // R5: the counter never passes the larger threshold
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < int'(CMAX));

endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
module irq_combine #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] filt_n,
  input  logic              snap,
  output logic              irq_n,
  output logic              pull_en,
  output logic [NUM_CH-1:0] status
);

  logic              irq_n_q;
  logic              pull_q;
  logic [NUM_CH-1:0] status_q;
  logic              all_idle;

  assign all_idle = &filt_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q <= 1'b1;
      pull_q  <= 1'b0;
    end else begin
      irq_n_q <= all_idle;
      pull_q  <= ~all_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       status_q <= '0;
    else if (snap) status_q <= ~filt_n;
  end

  assign irq_n   = irq_n_q;
  assign pull_en = pull_q;
  assign status  = status_q;

  // R1: outputs leave reset inactive
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n_q && !pull_q && (status_q == '0)));

  // R8: pad enable and level never agree
  a_r8_pull_inverse: assert property (@(posedge clk) disable iff (rst)
    pull_q != irq_n_q);

  // R2: any active filtered line pulls the merged request low
  a_r2_any_active: assert property (@(posedge clk) disable iff (rst)
    (filt_n != '1) |=> !irq_n_q);

  // R6: a strobe loads the active channels
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    snap |=> (status_q == ~$past(filt_n)));

  // R7: no strobe, no change
  a_r7_status_hold: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(status_q));

endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH          = DEF_NUM_CH,
  parameter int unsigned SYNC_STAGES     = DEF_SYNC,
  parameter int unsigned LOW_REJECT_CYC  = DEF_LOW_CYC,
  parameter int unsigned HIGH_REJECT_CYC = DEF_HIGH_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_in_n,
  input  logic              snap_req,
  output logic              irq_out_n,
  output logic              irq_pull_en,
  output logic [NUM_CH-1:0] irq_status
);

  logic [NUM_CH-1:0] sync_n;
  logic [NUM_CH-1:0] filt_n;

  irq_sync #(
    .WIDTH  (NUM_CH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in_n),
    .q   (sync_n)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      irq_glitch_filter #(
        .LOW_CYC  (LOW_REJECT_CYC),
        .HIGH_CYC (HIGH_REJECT_CYC)
      ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .sync_n (sync_n[ch]),
        .filt_n (filt_n[ch])
      );
    end
  endgenerate

  irq_combine #(
    .NUM_CH (NUM_CH)
  ) u_comb (
    .clk     (clk),
    .rst     (rst),
    .filt_n  (filt_n),
    .snap    (snap_req),
    .irq_n   (irq_out_n),
    .pull_en (irq_pull_en),
    .status  (irq_status)
  );

  // R9: a line idle at the synchronizer for a whole cycle cannot newly become active
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (sync_n == '1 && filt_n == '1) |=> (filt_n == '1));

endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

  localparam int NCH  = 4;
  localparam int SYNC = 2;
  localparam int LOWC = 50;
  localparam int HIGC = 25;
  localparam int LAT_LO = SYNC + LOWC + 1;
  localparam int LAT_HI = SYNC + HIGC + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] irq_in_n = '1;
  logic           snap_req = 1'b0;
  logic           irq_out_n;
  logic           irq_pull_en;
  logic [NCH-1:0] irq_status;

  irq_aggregator #(
    .NUM_CH (NCH), .SYNC_STAGES (SYNC),
    .LOW_REJECT_CYC (LOWC), .HIGH_REJECT_CYC (HIGC)
  ) uut (
    .clk (clk), .rst (rst), .irq_in_n (irq_in_n), .snap_req (snap_req),
    .irq_out_n (irq_out_n), .irq_pull_en (irq_pull_en), .irq_status (irq_status)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int             at;
    int             kind;   // 0: level and pad enable, 1: status
    logic [NCH-1:0] val;
    string          req;
  } exp_t;

  exp_t exp_q[$];

  task automatic push_exp(input int at, input int kind, input logic [NCH-1:0] val, input string req);
    exp_t e;
    int i;
    e.at = at; e.kind = kind; e.val = val; e.req = req;
    i = 0;
    while (i < exp_q.size() && exp_q[i].at <= at) i++;
    exp_q.insert(i, e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, expv);
    end
  endtask

  // Monitor: pops expectations due in the current cycle
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.kind == 0) begin
          check(irq_out_n == e.val[0], e.req, irq_out_n, e.val[0]);
          check(irq_pull_en == !e.val[0], {e.req, "/R8"}, irq_pull_en, !e.val[0]);
        end else begin
          check(irq_status == e.val, e.req, irq_status, e.val);
        end
      end
    end
  end

  task automatic goto(input int t);
    while (cyc < t) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic set_ch(input int ch, input logic v, output int c);
    @(posedge clk); #2;
    irq_in_n[ch] = v;
    c = cyc;
  endtask

  task automatic snap(output int s);
    @(posedge clk); #2;
    snap_req = 1'b1;
    s = cyc;
    @(posedge clk); #2;
    snap_req = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, c1, g, r, d, e, s;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1: reset state
    check(irq_out_n == 1'b1, "R1 level", irq_out_n, 1);
    check(irq_pull_en == 1'b0, "R1 pad", irq_pull_en, 0);
    check(irq_status == '0, "R1 status", irq_status, 0);
    goto(cyc + 5);

    // R5: the default latencies fit the timing budget at 50 MHz
    check(LAT_LO * 20 <= 4000, "R5 assert budget", LAT_LO * 20, 4000);
    check(LAT_HI * 20 <= 2000, "R5 release budget", LAT_HI * 20, 2000);

    // R3: low pulse one cycle short is rejected
    set_ch(0, 1'b0, c);
    push_exp(c + LAT_LO - 1, 0, 4'h1, "R3 short low");
    push_exp(c + LAT_LO,     0, 4'h1, "R3 short low");
    push_exp(c + LAT_LO + 3, 0, 4'h1, "R3 short low");
    goto(c + LOWC - 2);
    set_ch(0, 1'b1, c1);
    goto(c + LOWC + HIGC + 10);

    // R3/R5: low pulse of exact length accepted, then released with exact latency
    set_ch(1, 1'b0, c);
    push_exp(c + LAT_LO - 1, 0, 4'h1, "R5 before assert");
    push_exp(c + LAT_LO,     0, 4'h0, "R3 exact low");
    goto(c + LOWC - 1);
    set_ch(1, 1'b1, c1);
    push_exp(c1 + LAT_HI - 1, 0, 4'h0, "R5 before release");
    push_exp(c1 + LAT_HI,     0, 4'h1, "R5 release");
    goto(c1 + HIGC + 10);

    // R4: short high gap on an active line is ignored
    set_ch(2, 1'b0, c);
    goto(c + LOWC + 10);
    set_ch(2, 1'b1, g);
    push_exp(g, 0, 4'h0, "R4 active before gap");
    push_exp(g + LAT_HI - 1, 0, 4'h0, "R4 short gap");
    push_exp(g + LAT_HI,     0, 4'h0, "R4 short gap");
    push_exp(g + LAT_HI + 3, 0, 4'h0, "R4 short gap");
    goto(g + HIGC - 2);
    set_ch(2, 1'b0, c1);
    goto(g + HIGC + 10);
    set_ch(2, 1'b1, r);
    push_exp(r + LAT_HI - 1, 0, 4'h0, "R4 full gap");
    push_exp(r + LAT_HI,     0, 4'h1, "R4 full gap");
    goto(r + HIGC + 10);

    // R2/R6/R7: two overlapping channels
    set_ch(0, 1'b0, c);
    goto(c + 9);
    set_ch(3, 1'b0, c1);
    push_exp(c + LAT_LO, 0, 4'h0, "R2 first channel");
    goto(c1 + LOWC + 5);
    snap(s);
    push_exp(s + 1, 1, 4'b1001, "R6 two active");
    set_ch(0, 1'b1, d);
    push_exp(d + LAT_HI + 2, 0, 4'h0, "R2 one still active");
    goto(d + HIGC + 8);
    snap(s);
    push_exp(s + 1, 1, 4'b1000, "R6 one active");
    set_ch(3, 1'b1, e);
    push_exp(e + LAT_HI - 1, 0, 4'h0, "R2 last release");
    push_exp(e + LAT_HI,     0, 4'h1, "R2 last release");
    push_exp(e + LAT_HI + 2, 1, 4'b1000, "R7 hold without strobe");
    goto(e + HIGC + 10);
    snap(s);
    push_exp(s + 1, 1, 4'b0000, "R7 not sticky");
    goto(s + 4);

    // R9: each channel alone drives the output and reports itself
    for (int ch = 0; ch < NCH; ch++) begin
      set_ch(ch, 1'b0, c);
      push_exp(c + LAT_LO, 0, 4'h0, "R9 channel assert");
      goto(c + LOWC + 8);
      snap(s);
      push_exp(s + 1, 1, 4'(1 << ch), "R9 channel status");
      set_ch(ch, 1'b1, r);
      push_exp(r + LAT_HI, 0, 4'h1, "R9 channel release");
      goto(r + HIGC + 8);
    end

    // R1: reset in the middle of an active request
    set_ch(1, 1'b0, c);
    goto(c + LOWC + 8);
    snap(s);
    goto(s + 3);
    check(irq_out_n == 1'b0, "R1 active before reset", irq_out_n, 0);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    c = cyc;
    check(irq_out_n == 1'b1, "R1 level after reset", irq_out_n, 1);
    check(irq_status == '0, "R1 status after reset", irq_status, 0);
    // The held low is re-qualified from scratch after reset
    push_exp(c + 5, 0, 4'h1, "R1 requalify");
    goto(c + LOWC + SYNC + 8);
    push_exp(cyc, 0, 4'h0, "R1 requalified");
    goto(cyc + 2);
    set_ch(1, 1'b1, r);
    goto(r + HIGC + 8);

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule